// File: doc/BRIEF.md
# Three-Channel LED PWM Generator

This block produces three pulse-width-modulated enable signals, one each for the red, green and blue LED drivers of a lighting module. A single free-running period counter is shared by all three channels. Each channel compares the counter against its own active duty value. The output is asserted while the count is below that value, so the duty value is the on-time in counts out of a period of 2^CNT_W enabled clock cycles. With the default 12-bit width and a clock of about 2.5 MHz, the output rate is about 610 Hz.

A feedback controller elsewhere in the chip drives the duty inputs, and it may change them at any time. The block samples them, together with the polarity input, only at the period boundary. A running period therefore never carries a mix of old and new settings. The polarity input makes the outputs active-high or active-low, to match the enable pin of the LED driver. A clock-enable input freezes the block for sleep. An asynchronous active-low reset returns the block to its idle state.

Top module: `rgb_pwm`

## Requirements
- R1: The period counter advances by one on every enabled clock, wraps from 2^CNT_W-1 to 0, and each output is asserted exactly while the count is below its channel's active duty value.
- R2: An active duty of 0 keeps the channel deasserted for the whole period. An active duty of 2^CNT_W-1 keeps it asserted on every count except the last.
- R3: Duty inputs are sampled only on the enabled clock edge at which the counter goes from 2^CNT_W-1 to 0. A duty change in mid-period leaves the rest of that period unchanged, and the new value applies from count 0.
- R4: `pol_low` = 0 makes the asserted level 1, and `pol_low` = 1 makes the asserted level 0. While the block runs, `pol_low` is sampled only at the same period boundary as the duties.
- R5: While `rst_n` is low, and after its release until the first enabled edge, every output sits at the deasserted level given directly by `pol_low`. Reset clears every register. The first enabled edge after reset starts count 0 and loads the duty and polarity inputs.
- R6: While `clk_en` is low, the counter and the active settings hold, and every output sits at the deasserted level given directly by `pol_low`. When enable returns, counting resumes from the held count.
- R7: The three channels are independent. Over an uninterrupted period, each channel is asserted for exactly its own duty count, whatever the other channels hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low freezes the block (sleep) |
| pol_low | input | 1 | 1 selects active-low outputs, 0 active-high |
| duty_r | input | CNT_W | Pending duty value, red channel |
| duty_g | input | CNT_W | Pending duty value, green channel |
| duty_b | input | CNT_W | Pending duty value, blue channel |
| pwm_r | output | 1 | Red LED driver enable |
| pwm_g | output | 1 | Green LED driver enable |
| pwm_b | output | 1 | Blue LED driver enable |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle between edges. They also assume that `clk_en` and `pol_low` are ordinary level signals, with no hazards that depend on edge order. The bench changes every input a quarter period after the rising edge and samples the outputs on the falling edge, so each sample sees a settled combination of state and inputs. Duty and polarity changes are placed deliberately in mid-period, during sleep and during reset. This tests the boundary sampling against inputs that move at arbitrary times.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;
    localparam int unsigned PWM_W_DEF = 12;
    localparam int unsigned NUM_CH    = 3;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } ch_e;
endpackage

// File: rtl/rgb_pwm_timebase.sv
// Shared period counter plus the polarity bit latched at each boundary.
module rgb_pwm_timebase #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         pol_in,
    output logic [W-1:0] cnt_q,
    output logic         started_q,
    output logic         pol_q,
    output logic         boundary
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         started;
        logic         pol;
    } tb_state_t;

    tb_state_t st_d, st_q;

    assign boundary = clk_en && (st_q.cnt == CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (boundary) begin
            st_d.started = 1'b1;
            st_d.pol     = pol_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: CNT_MAX, started: 1'b0, pol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q     = st_q.cnt;
    assign started_q = st_q.started;
    assign pol_q     = st_q.pol;
endmodule

// File: rtl/rgb_pwm_chan.sv
// One channel: active duty register loaded at the boundary, plus compare.
module rgb_pwm_chan #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] duty_in,
    input  logic [W-1:0] cnt,
    input  logic         run,
    input  logic         level_pol,
    output logic [W-1:0] duty_q,
    output logic         pwm
);
    typedef struct packed {
        logic [W-1:0] duty;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      on_w;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.duty = duty_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign on_w   = run && (cnt < st_q.duty);
    assign pwm    = on_w ^ level_pol;
    assign duty_q = st_q.duty;
endmodule

// File: rtl/rgb_pwm.sv
module rgb_pwm #(
    parameter int unsigned CNT_W = rgb_pwm_pkg::PWM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             pol_low,
    input  logic [CNT_W-1:0] duty_r,
    input  logic [CNT_W-1:0] duty_g,
    input  logic [CNT_W-1:0] duty_b,
    output logic             pwm_r,
    output logic             pwm_g,
    output logic             pwm_b
);
    localparam int unsigned NCH   = rgb_pwm_pkg::NUM_CH;
    localparam int unsigned I_RED = int'(rgb_pwm_pkg::CH_RED);
    localparam int unsigned I_GRN = int'(rgb_pwm_pkg::CH_GREEN);
    localparam int unsigned I_BLU = int'(rgb_pwm_pkg::CH_BLUE);

    logic [CNT_W-1:0]          cnt_w;
    logic                      started_w;
    logic                      pol_w;
    logic                      boundary_w;
    logic                      run_w;
    logic                      lvl_w;
    logic [NCH-1:0][CNT_W-1:0] duty_in_w;
    logic [NCH-1:0][CNT_W-1:0] duty_act_w;
    logic [NCH-1:0]            pwm_w;

    assign duty_in_w[I_RED] = duty_r;
    assign duty_in_w[I_GRN] = duty_g;
    assign duty_in_w[I_BLU] = duty_b;

    rgb_pwm_timebase #(.W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .pol_in    (pol_low),
        .cnt_q     (cnt_w),
        .started_q (started_w),
        .pol_q     (pol_w),
        .boundary  (boundary_w)
    );

    // Idle (reset, sleep, before first period): deasserted level from the pin.
    assign run_w = rst_n && clk_en && started_w;
    assign lvl_w = run_w ? pol_w : pol_low;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        rgb_pwm_chan #(.W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (boundary_w),
            .duty_in   (duty_in_w[ch]),
            .cnt       (cnt_w),
            .run       (run_w),
            .level_pol (lvl_w),
            .duty_q    (duty_act_w[ch]),
            .pwm       (pwm_w[ch])
        );
    end

    assign pwm_r = pwm_w[I_RED];
    assign pwm_g = pwm_w[I_GRN];
    assign pwm_b = pwm_w[I_BLU];
endmodule

// File: rtl/rgb_pwm_checker.sv
module rgb_pwm_checker #(
    parameter int unsigned W   = 12,
    parameter int unsigned NCH = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clk_en,
    input logic                  pol_in,
    input logic [W-1:0]          cnt,
    input logic                  started,
    input logic                  pol_q,
    input logic [NCH-1:0][W-1:0] duty_act,
    input logic [NCH-1:0]        pwm
);
    localparam logic [W-1:0] CNT_MAX = '1;

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && started && cnt != CNT_MAX) |=> (cnt == W'($past(cnt) + 1'b1)));

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cnt == CNT_MAX) |=> (cnt == '0 && started));

    p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en && cnt == CNT_MAX) |=> $stable(duty_act));

    p_pol_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en && cnt == CNT_MAX) |=> $stable(pol_q));

    p_prestart_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (pwm == {NCH{pol_in}}));

    p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(cnt));

    p_sleep_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (pwm == {NCH{pol_in}}));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch_chk
        p_zero_duty_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_en && started && duty_act[ch] == '0) |-> (pwm[ch] == pol_q));

        p_full_duty_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_en && started && duty_act[ch] == CNT_MAX && cnt != CNT_MAX)
                |-> (pwm[ch] != pol_q));
    end
endmodule

bind rgb_pwm rgb_pwm_checker #(.W(CNT_W), .NCH(NCH)) u_rgb_pwm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .pol_in   (pol_low),
    .cnt      (cnt_w),
    .started  (started_w),
    .pol_q    (pol_w),
    .duty_act (duty_act_w),
    .pwm      (pwm_w)
);

// File: tb/rgb_pwm_bench.sv
`timescale 1ns/1ps
module rgb_pwm_bench;
    localparam int unsigned W = 12;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en = 1'b1;
    logic         pol_low = 1'b1;
    logic [W-1:0] duty_r = '0;
    logic [W-1:0] duty_g = '0;
    logic [W-1:0] duty_b = '0;
    logic         pwm_r, pwm_g, pwm_b;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rgb_pwm #(.CNT_W(W)) u_rgb_pwm (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pol_low(pol_low),
        .duty_r(duty_r), .duty_g(duty_g), .duty_b(duty_b),
        .pwm_r(pwm_r), .pwm_g(pwm_g), .pwm_b(pwm_b)
    );

    // Reference model built from the requirements (bit order b,g,r).
    logic [W-1:0] m_cnt = MAXV;
    logic [W-1:0] m_duty [3];
    logic         m_pol = 1'b0;
    logic         m_started = 1'b0;

    initial begin
        for (int i = 0; i < 3; i++) m_duty[i] = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt     <= MAXV;
            m_pol     <= 1'b0;
            m_started <= 1'b0;
            for (int i = 0; i < 3; i++) m_duty[i] <= '0;
        end else if (clk_en) begin
            m_cnt <= m_cnt + 1'b1;
            if (m_cnt == MAXV) begin
                m_started <= 1'b1;
                m_pol     <= pol_low;
                m_duty[0] <= duty_r;
                m_duty[1] <= duty_g;
                m_duty[2] <= duty_b;
            end
        end
    end

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    // Driver side of the scoreboard: expected levels for this cycle.
    always @(negedge clk) begin
        item_t it;
        logic  run;
        run = rst_n && clk_en && m_started;
        for (int i = 0; i < 3; i++)
            it.exp[i] = run ? ((m_cnt < m_duty[i]) ^ m_pol) : pol_low;
        if (!rst_n)                it.tag = "R5";
        else if (!clk_en)          it.tag = "R6";
        else if (!m_started)       it.tag = "R5";
        else if (m_duty[0] == 0 || m_duty[0] == MAXV || m_duty[1] == 0 ||
                 m_duty[1] == MAXV || m_duty[2] == 0 || m_duty[2] == MAXV)
                                   it.tag = "R2";
        else if (m_pol)            it.tag = "R4";
        else                       it.tag = "R1";
        sb_q.push_back(it);
    end

    // Monitor: pops expected items and tallies on-time per clean period.
    int  hi_cnt [3];
    bit  clean = 1'b0;

    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t      it;
            logic [2:0] act;
            logic       run;
            it  = sb_q.pop_front();
            act = {pwm_b, pwm_g, pwm_r};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s pwm(b,g,r) actual=%b expected=%b cnt=%0d",
                         it.tag, act, it.exp, m_cnt);
            end
            run = rst_n && clk_en && m_started;
            if (m_cnt == 0) begin
                clean = run;
                for (int i = 0; i < 3; i++) hi_cnt[i] = 0;
            end
            if (!run) clean = 1'b0;
            else for (int i = 0; i < 3; i++)
                if (act[i] != m_pol) hi_cnt[i]++;
            if (m_cnt == MAXV && clean) begin
                for (int i = 0; i < 3; i++) begin
                    checks++;
                    if (hi_cnt[i] != int'(m_duty[i])) begin
                        failures++;
                        $display("FAIL R7 ch%0d on-count actual=%0d expected=%0d",
                                 i, hi_cnt[i], m_duty[i]);
                    end
                end
                clean = 1'b0;
            end
        end
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s directed actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wait_cnt(input logic [W-1:0] v);
        do begin
            @(posedge clk);
            #5;
        end while (m_cnt != v);
    endtask

    task automatic wait_wraps(input int n);
        for (int k = 0; k < n; k++) begin
            wait_cnt(MAXV);
            wait_cnt('0);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset with active-low polarity: idle level is 1 on all outputs.
        repeat (5) @(posedge clk);
        #5;
        check1("R5", pwm_r & pwm_g & pwm_b, 1'b1);
        pol_low = 1'b0;
        duty_r  = '0;
        duty_g  = MAXV;
        duty_b  = 12'd1000;
        rst_n   = 1'b1;
        #1;
        check1("R5", pwm_r | pwm_g | pwm_b, 1'b0);
        wait_wraps(2);

        // Mid-period duty change must wait for the boundary.
        wait_cnt(12'd500);
        duty_r = 12'd2048;
        duty_b = 12'd7;
        wait_cnt(12'd600);
        check1("R3", pwm_r, 1'b0);
        check1("R3", pwm_b, 1'b1);
        wait_cnt(12'd10);
        check1("R3", pwm_r, 1'b1);
        check1("R3", pwm_b, 1'b0);

        // Mid-period polarity change must wait for the boundary.
        wait_cnt(12'd100);
        pol_low = 1'b1;
        wait_cnt(12'd200);
        check1("R4", pwm_g, 1'b1);
        wait_cnt(12'd5);
        check1("R4", pwm_g, 1'b0);
        wait_wraps(1);

        // Sleep in mid-period, with a polarity change while asleep.
        wait_cnt(12'd1234);
        clk_en = 1'b0;
        repeat (150) @(posedge clk);
        #5;
        check1("R6", pwm_r | pwm_g | pwm_b, 1'b0 ^ pol_low);
        pol_low = 1'b0;
        duty_g  = 12'd3;
        repeat (150) @(posedge clk);
        #5;
        check1("R6", pwm_r | pwm_g | pwm_b, 1'b0);
        pol_low = 1'b1;
        clk_en  = 1'b1;
        wait_wraps(1);

        // Reset in mid-period, released with active-low polarity.
        wait_cnt(12'd2000);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        duty_r = MAXV;
        duty_g = '0;
        duty_b = 12'd1;
        rst_n  = 1'b1;
        #1;
        check1("R5", pwm_r & pwm_g & pwm_b, 1'b1);
        wait_wraps(2);

        // Independent channels with assorted values, active-high.
        pol_low = 1'b0;
        duty_r  = 12'd1;
        duty_g  = 12'd2;
        duty_b  = 12'd3;
        wait_wraps(1);
        duty_r = 12'd4094;
        duty_g = 12'd2047;
        duty_b = MAXV;
        wait_wraps(2);

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule